// File: doc/BRIEF.md
# Serial Flash Read Bridge with I/O Window Decode

This block lets a host fetch bytes from a serial flash as if it were plain memory. A host memory read becomes one SPI read transaction: the bridge selects the flash and sends the read opcode 03h. It then sends a 24-bit byte address, clocks in one data byte and completes the host cycle with that byte. SPI runs in mode 0 and the serial clock is the system clock divided by two.

The bridge also decodes a small host I/O space. A configuration index/data port pair gives access to two base-address byte registers and a read-only status byte. The base they form places an 8-byte I/O window, backed by eight byte registers, anywhere in the 16-bit I/O space. A strap input is captured while reset is asserted. It decides whether the SPI pins ever leave their idle levels. With the strap low, memory reads complete at once with FFh.

The host side uses a one-cycle request pulse carrying space, direction, address and write data. It is answered by a one-cycle ready pulse with read data. The host waits for ready before it issues the next request.

The host controller has three states:
- H_IDLE → H_FLASH on a memory read while SPI is enabled.
- H_IDLE → H_ACK on any other request.
- H_FLASH → H_ACK when the engine reports done.
- H_ACK → H_IDLE always.

The serial engine also has three states:
- E_IDLE → E_SHIFT on start.
- E_SHIFT → E_DONE after the falling half of the 40th bit.
- E_DONE → E_IDLE always.

Top module: `spi_flash_bridge`

## Requirements
- R1: After reset, spi_cs_n_o is 1, spi_sclk_o is 0 and host_ready_o is 0. Configuration registers 62h and 63h read 00h, so the window starts at I/O address 0000h.
- R2: The SPI enable equals the strap input as sampled during reset. Later changes of the strap have no effect until the next reset.
- R3: Configuration index 24h reads back with bit 1 equal to the SPI enable and all other bits 0. Writes to it have no effect.
- R4: The I/O port CFG_PORT (default 002Eh) holds the index and reads back what was written. Port CFG_PORT+1 accesses the register selected by the index. Indices 62h (high byte) and 63h (low byte) of the window base are read/write. Other indices read 00h.
- R5: I/O addresses base through base+7 (no wrap past FFFFh) reach eight byte registers that read back what was written. The index/data ports take priority where they overlap.
- R6: I/O writes outside the window and outside the port pair change nothing. I/O reads there return FFh.
- R7: A memory read with SPI enabled drives spi_cs_n_o low for one transaction of 40 serial clocks. It first sends opcode 03h, then address bits 23..0, each most significant bit first. spi_mosi_o is stable while spi_sclk_o rises, and spi_sclk_o is low whenever spi_cs_n_o is high.
- R8: The byte sampled on spi_miso_i at the rising edges of clocks 33 to 40 (most significant bit first) is returned on host_rdata_o. It comes with a one-cycle host_ready_o pulse, and spi_cs_n_o is already high by then.
- R9: spi_sclk_o has a period of two system clock cycles, high for one and low for one.
- R10: With SPI disabled, a memory read returns FFh, spi_cs_n_o stays 1 and spi_sclk_o stays 0.
- R11: A memory write produces a ready pulse and no SPI activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_spi_i | input | 1 | SPI enable strap, sampled while reset is low |
| host_req_i | input | 1 | One-cycle request strobe |
| host_io_i | input | 1 | 1 selects I/O space, 0 selects memory space |
| host_we_i | input | 1 | 1 for write, 0 for read |
| host_addr_i | input | 24 | Byte address (I/O uses the low 16 bits) |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data, valid with ready |
| host_ready_o | output | 1 | One-cycle completion strobe |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_cs_n_o | output | 1 | Active-low flash select |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench builds the bridge with its default parameters: three address bytes, an 8-byte window and the port pair at 002Eh. These keep the full 40-bit command/address/data frame visible at the pins against a bench flash model. The model checks the opcode, every address bit and the clock period. The 16-bit base registers can be moved to an unaligned base such as 0123h, so the first and last window bytes and both neighbours just outside are reachable. Two resets with different strap levels exercise both the enabled path and the quiet, FFh-returning disabled path.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

    typedef enum logic [1:0] {
        H_IDLE,
        H_FLASH,
        H_ACK
    } host_state_e;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SHIFT,
        E_DONE
    } eng_state_e;

    localparam logic [7:0] IDX_STATUS  = 8'h24;
    localparam logic [7:0] IDX_BASE_HI = 8'h62;
    localparam logic [7:0] IDX_BASE_LO = 8'h63;

endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_bridge_pkg::*;
#(
    parameter int unsigned IO_AW    = 16,
    parameter int unsigned CFG_PORT = 'h2E,
    parameter int unsigned WIN_SIZE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [IO_AW-1:0] addr_i,
    input  logic [7:0]       wdata_i,
    input  logic             spi_en_i,
    output logic [7:0]       rdata_o
);
    localparam int unsigned WIN_LOG2 = $clog2(WIN_SIZE);

    logic [7:0]       index_q;
    logic [7:0]       base_hi_q;
    logic [7:0]       base_lo_q;
    logic [7:0]       win_q [WIN_SIZE];
    logic [IO_AW-1:0] base;
    logic [IO_AW:0]   offset;
    logic             sel_idx;
    logic             sel_dat;
    logic             in_win;
    logic [WIN_LOG2-1:0] slot;

    assign base    = IO_AW'({base_hi_q, base_lo_q});
    assign offset  = {1'b0, addr_i} - {1'b0, base};
    assign sel_idx = (addr_i == IO_AW'(CFG_PORT));
    assign sel_dat = (addr_i == IO_AW'(CFG_PORT + 1));
    assign in_win  = !sel_idx && !sel_dat && (offset < (IO_AW + 1)'(WIN_SIZE));
    assign slot    = offset[WIN_LOG2-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q   <= 8'h00;
            base_hi_q <= 8'h00;
            base_lo_q <= 8'h00;
        end else if (wr_i) begin
            if (sel_idx) begin
                index_q <= wdata_i;
            end else if (sel_dat) begin
                if (index_q == IDX_BASE_HI) base_hi_q <= wdata_i;
                if (index_q == IDX_BASE_LO) base_lo_q <= wdata_i;
            end
        end
    end

    for (genvar g = 0; g < WIN_SIZE; g++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_q[g] <= 8'h00;
            end else if (wr_i && in_win && (slot == WIN_LOG2'(g))) begin
                win_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = 8'hFF;
        if (sel_idx) begin
            rdata_o = index_q;
        end else if (sel_dat) begin
            unique case (index_q)
                IDX_STATUS:  rdata_o = {6'b0, spi_en_i, 1'b0};
                IDX_BASE_HI: rdata_o = base_hi_q;
                IDX_BASE_LO: rdata_o = base_lo_q;
                default:     rdata_o = 8'h00;
            endcase
        end else if (in_win) begin
            rdata_o = win_q[slot];
        end
    end

endmodule

// File: rtl/spi_read_engine.sv
module spi_read_engine
    import spi_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter logic [7:0]  OPCODE = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              done_o,
    output logic [7:0]        data_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int unsigned TOTAL = 8 + ADDR_W + 8;
    localparam int unsigned CNT_W = $clog2(TOTAL);

    eng_state_e       state_q, state_d;
    logic             half_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TOTAL-1:0] tx_q;
    logic [7:0]       rx_q;
    logic             last_bit;

    assign last_bit = half_q && (cnt_q == CNT_W'(TOTAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= E_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_IDLE:  if (start_i) state_d = E_SHIFT;
            E_SHIFT: if (last_bit) state_d = E_DONE;
            E_DONE:  state_d = E_IDLE;
            default: state_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            cnt_q  <= '0;
            tx_q   <= '0;
            rx_q   <= 8'h00;
        end else begin
            unique case (state_q)
                E_IDLE: begin
                    half_q <= 1'b0;
                    cnt_q  <= '0;
                    if (start_i) tx_q <= {OPCODE, addr_i, 8'h00};
                end
                E_SHIFT: begin
                    if (!half_q) begin
                        half_q <= 1'b1;
                        rx_q   <= {rx_q[6:0], miso_i};
                    end else begin
                        half_q <= 1'b0;
                        tx_q   <= tx_q << 1;
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end
                default: half_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        cs_n_o = (state_q != E_SHIFT);
        sclk_o = (state_q == E_SHIFT) && half_q;
        mosi_o = (state_q == E_SHIFT) && tx_q[TOTAL-1];
        done_o = (state_q == E_DONE);
        data_o = rx_q;
    end

endmodule

// File: rtl/spi_flash_bridge.sv
module spi_flash_bridge
    import spi_bridge_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 3,
    parameter int unsigned IO_AW      = 16,
    parameter int unsigned CFG_PORT   = 'h2E,
    parameter int unsigned WIN_SIZE   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strap_spi_i,
    input  logic                      host_req_i,
    input  logic                      host_io_i,
    input  logic                      host_we_i,
    input  logic [8*ADDR_BYTES-1:0]   host_addr_i,
    input  logic [7:0]                host_wdata_i,
    output logic [7:0]                host_rdata_o,
    output logic                      host_ready_o,
    output logic                      spi_sclk_o,
    output logic                      spi_cs_n_o,
    output logic                      spi_mosi_o,
    input  logic                      spi_miso_i
);
    localparam int unsigned MEM_AW = 8 * ADDR_BYTES;

    host_state_e state_q, state_d;
    logic        spi_en_q;
    logic [7:0]  rdata_q;
    logic [7:0]  cfg_rdata;
    logic [7:0]  eng_data;
    logic        eng_done;
    logic        accept;
    logic        flash_rd;
    logic        cfg_wr;

    // Strap capture: follows the pin only while reset is held (R2)
    always_ff @(posedge clk) begin
        if (!rst_n) spi_en_q <= strap_spi_i;
    end

    assign accept   = (state_q == H_IDLE) && host_req_i;
    assign flash_rd = accept && !host_io_i && !host_we_i && spi_en_q;
    assign cfg_wr   = accept && host_io_i && host_we_i;

    spi_cfg_regs #(
        .IO_AW   (IO_AW),
        .CFG_PORT(CFG_PORT),
        .WIN_SIZE(WIN_SIZE)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .addr_i  (host_addr_i[IO_AW-1:0]),
        .wdata_i (host_wdata_i),
        .spi_en_i(spi_en_q),
        .rdata_o (cfg_rdata)
    );

    spi_read_engine #(
        .ADDR_W(MEM_AW),
        .OPCODE(8'h03)
    ) i_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(flash_rd),
        .addr_i (host_addr_i),
        .done_o (eng_done),
        .data_o (eng_data),
        .sclk_o (spi_sclk_o),
        .cs_n_o (spi_cs_n_o),
        .mosi_o (spi_mosi_o),
        .miso_i (spi_miso_i)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= H_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE: begin
                if (flash_rd)        state_d = H_FLASH;
                else if (accept)     state_d = H_ACK;
            end
            H_FLASH: if (eng_done)   state_d = H_ACK;
            H_ACK:                   state_d = H_IDLE;
            default:                 state_d = H_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
        end else if (accept && !flash_rd) begin
            rdata_q <= host_io_i ? cfg_rdata : 8'hFF;
        end else if ((state_q == H_FLASH) && eng_done) begin
            rdata_q <= eng_data;
        end
    end

    always_comb begin
        host_ready_o = (state_q == H_ACK);
        host_rdata_o = rdata_q;
    end

endmodule

// File: rtl/spi_bridge_checker.sv
module spi_bridge_checker (
    input logic clk,
    input logic rst_n,
    input logic spi_en,
    input logic sclk,
    input logic cs_n,
    input logic ready,
    input logic req,
    input logic io,
    input logic we
);
    assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(spi_en));

    assert_idle_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_ready_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cs_n);

    assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_sclk_high_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> (cs_n && !sclk));

    assert_mem_write_no_spi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !io && we && cs_n && !ready) |=> cs_n);
endmodule

bind spi_flash_bridge spi_bridge_checker i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .spi_en(spi_en_q),
    .sclk  (spi_sclk_o),
    .cs_n  (spi_cs_n_o),
    .ready (host_ready_o),
    .req   (host_req_i),
    .io    (host_io_i),
    .we    (host_we_i)
);

// File: tb/test_spi_flash_bridge.sv
`timescale 1ns/1ps
module test_spi_flash_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b1;
    logic        req = 1'b0, io = 1'b0, we = 1'b0;
    logic [23:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready, sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int checks = 0, fails = 0, acks = 0, cs_falls = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         chk_q [$];

    // flash model state
    int          f_bits = 0, bad_period = 0;
    logic [31:0] f_cmd = '0;
    logic [7:0]  f_data = '0;
    realtime     last_rise = 0;
    bit          have_rise = 0;

    always #5 clk = ~clk;

    spi_flash_bridge i_spi_flash_bridge (
        .clk(clk), .rst_n(rst_n), .strap_spi_i(strap),
        .host_req_i(req), .host_io_i(io), .host_we_i(we),
        .host_addr_i(addr), .host_wdata_i(wdata),
        .host_rdata_o(rdata), .host_ready_o(ready),
        .spi_sclk_o(sclk), .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
    );

    function automatic logic [7:0] fpat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // flash responder
    always @(negedge cs_n) begin
        cs_falls++;
        f_bits = 0; f_cmd = '0; have_rise = 0;
    end
    always @(posedge sclk) begin
        if (!cs_n) begin
            if (f_bits < 32) f_cmd = {f_cmd[30:0], mosi};
            f_bits++;
            if (have_rise && ($realtime - last_rise != 20.0)) bad_period++;
            last_rise = $realtime; have_rise = 1;
            if (f_bits == 32) f_data = fpat(f_cmd[23:0]);
        end
    end
    always @(negedge sclk) begin
        if (!cs_n && f_bits >= 32 && f_bits < 40) miso = f_data[39 - f_bits];
    end

    // monitor: pops the scoreboard on each ready pulse
    always @(negedge clk) begin
        if (ready) begin
            acks++;
            check(cs_n, "R8 select released at ready", cs_n, 1);
            if (exp_q.size() == 0) begin
                check(0, "unexpected ready", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                automatic bit         c = chk_q.pop_front();
                if (c) check(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic access(input bit is_io, input bit is_wr, input logic [23:0] a,
                          input logic [7:0] wd, input logic [7:0] exp, input bit chk,
                          input string tag);
        int start;
        start = acks;
        exp_q.push_back(exp); tag_q.push_back(tag); chk_q.push_back(chk);
        @(negedge clk);
        req = 1; io = is_io; we = is_wr; addr = a; wdata = wd;
        @(negedge clk);
        req = 0;
        while (acks == start) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
        access(1, 1, 24'h00002E, idx, 0, 0, "idx");
        access(1, 1, 24'h00002F, val, 0, 0, "dat");
    endtask

    task automatic cfg_read(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        access(1, 1, 24'h00002E, idx, 0, 0, "idx");
        access(1, 0, 24'h00002F, 0, exp, 1, tag);
    endtask

    task automatic flash_read(input logic [23:0] a);
        int falls0;
        falls0 = cs_falls;
        access(0, 0, a, 0, fpat(a), 1, "R8 flash data");
        check(f_cmd == {8'h03, a}, "R7 opcode and address", f_cmd, {8'h03, a});
        check(f_bits == 40, "R7 clock count", f_bits, 40);
        check(bad_period == 0, "R9 sclk period", bad_period, 0);
        check(cs_falls == falls0 + 1, "R7 one select", cs_falls, falls0 + 1);
    endtask

    task automatic do_reset(input bit s);
        strap = s; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        do_reset(1);
        // R1 reset state
        check(cs_n === 1'b1, "R1 cs_n at reset", cs_n, 1);
        check(sclk === 1'b0, "R1 sclk at reset", sclk, 0);
        check(ready === 1'b0, "R1 ready at reset", ready, 0);
        cfg_read(8'h62, 8'h00, "R1 base high reset");
        cfg_read(8'h63, 8'h00, "R1 base low reset");
        // R3 status
        cfg_read(8'h24, 8'h02, "R3 status enabled");
        cfg_write(8'h24, 8'hFF);
        cfg_read(8'h24, 8'h02, "R3 status write ignored");
        cfg_read(8'h40, 8'h00, "R4 unknown index reads zero");
        // R4 index readback and base
        access(1, 1, 24'h00002E, 8'h63, 0, 0, "idx");
        access(1, 0, 24'h00002E, 0, 8'h63, 1, "R4 index readback");
        cfg_write(8'h62, 8'h03);
        cfg_write(8'h63, 8'hF8);
        cfg_read(8'h62, 8'h03, "R4 base high");
        cfg_read(8'h63, 8'hF8, "R4 base low");
        // R5 window 03F8..03FF
        for (int i = 0; i < 8; i++) access(1, 1, 24'h0003F8 + i, 8'hA0 + i, 0, 0, "w");
        for (int i = 0; i < 8; i++) access(1, 0, 24'h0003F8 + i, 0, 8'hA0 + i, 1, "R5 window readback");
        // R6 outside
        access(1, 1, 24'h0003F7, 8'h11, 0, 0, "w");
        access(1, 1, 24'h000400, 8'h22, 0, 0, "w");
        access(1, 0, 24'h0003F7, 0, 8'hFF, 1, "R6 below window");
        access(1, 0, 24'h000400, 0, 8'hFF, 1, "R6 above window");
        access(1, 0, 24'h0003F8, 0, 8'hA0, 1, "R6 first slot untouched");
        access(1, 0, 24'h0003FF, 0, 8'hA7, 1, "R6 last slot untouched");
        // R5 unaligned base 0123h: window 0123..012A
        cfg_write(8'h62, 8'h01);
        cfg_write(8'h63, 8'h23);
        access(1, 1, 24'h000123, 8'h5C, 0, 0, "w");
        access(1, 1, 24'h00012A, 8'hC5, 0, 0, "w");
        access(1, 0, 24'h000123, 0, 8'h5C, 1, "R5 unaligned first");
        access(1, 0, 24'h00012A, 0, 8'hC5, 1, "R5 unaligned last");
        access(1, 0, 24'h00012B, 0, 8'hFF, 1, "R6 past unaligned window");
        access(1, 0, 24'h000122, 0, 8'hFF, 1, "R6 before unaligned window");
        // R7 R8 R9 flash reads
        flash_read(24'h000000);
        flash_read(24'hFFFFFF);
        flash_read(24'hA5C3F0);
        flash_read(24'h123456);
        // R11 memory write
        begin
            int f0;
            f0 = cs_falls;
            access(0, 1, 24'h001000, 8'h77, 0, 0, "R11 write ready");
            check(cs_falls == f0, "R11 no SPI on write", cs_falls, f0);
        end
        // R2 strap change after reset ignored
        strap = 0;
        repeat (2) @(negedge clk);
        flash_read(24'h00BEEF);
        cfg_read(8'h24, 8'h02, "R2 enable held after strap drop");
        // R10 disabled
        do_reset(0);
        cfg_read(8'h24, 8'h00, "R3 status disabled");
        begin
            int f0;
            f0 = cs_falls;
            access(0, 0, 24'h000010, 0, 8'hFF, 1, "R10 disabled read FF");
            check(cs_falls == f0, "R10 no select while disabled", cs_falls, f0);
            strap = 1;
            repeat (2) @(negedge clk);
            access(0, 0, 24'h000020, 0, 8'hFF, 1, "R2 strap rise ignored");
            check(cs_falls == f0, "R2 still no select", cs_falls, f0);
        end
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule